// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Capture

This block keeps wall-clock time as two counts: a seconds count and a sub-second count that runs from 0 to 999. Both advance from a single-cycle enable pulse that arrives once per millisecond. The counter never stops on its own, so it keeps time while the rest of the chip is idle. Software reaches it through a plain 32-bit register port with a read strobe, a write strobe and a byte offset.

Software cannot read seconds and milliseconds in one access, so the two reads could straddle a seconds rollover. To avoid this, a read of the milliseconds register also copies the live seconds count into a separate capture register in the same clock edge. Software reads milliseconds first, then the capture register, and forms seconds * 1000 + milliseconds from a pair that belongs together. Only one agent may run this two-read sequence at a time, because a second milliseconds read replaces the captured value. Software may also load the seconds count directly, which restarts the sub-second count.

Top module: `rtcShadowTimer`

## Requirements
- R1: After reset the seconds count, the millisecond count, the capture register and `rdData` are all zero.
- R2: Each cycle with `tickEn` high raises the millisecond count by one. Cycles without `tickEn` leave both counts unchanged.
- R3: The millisecond count never exceeds 999. A tick at 999 returns it to 0 and raises seconds by one on the same clock edge.
- R4: Seconds is 32 bits wide and a tick that carries out of 0xFFFFFFFF wraps it to 0.
- R5: A read at offset 0x10 returns the millisecond count, zero-extended. On the same edge it copies the seconds value held before that edge into the capture register.
- R6: A read at offset 0x0C returns the capture register. The capture register keeps its value until the next read at 0x10, whatever happens to the live seconds count in between.
- R7: A write at offset 0x08 loads seconds from `wrData` and clears the millisecond count. A tick in the same cycle has no effect.
- R8: Writes at offsets 0x0C and 0x10, and at any unmapped offset, change no state.
- R9: Read data appears on `rdData` one cycle after the `rdEn` cycle and holds until the next read. Offset 0x08 returns live seconds, and every unmapped offset returns zero.
- R10: Reads at offsets other than 0x10 leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle pulse per millisecond |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |

## Verification
Directed cases exercise the counter at the millisecond rollover and at the 32-bit seconds rollover. These show whether the carry lands on the same edge and whether the wrap is clean. Other directed cases pair a milliseconds read with later seconds writes and ticks, which separates a true capture register from a plain alias of live seconds. They also show whether reads of other offsets disturb the captured value. Writes to the read-only offsets and to unmapped offsets confirm that the state is untouched. A seeded random stream then mixes ticks, writes, mapped reads and unmapped reads. Every read result is compared with a bench model, and the stream covers a tick and a seconds write landing in the same cycle.

// File: rtl/rtcPkg.sv
package rtcPkg;
  typedef struct packed {
    logic loadSec;
    logic capShadow;
    logic rdSec;
    logic rdShadow;
    logic rdMs;
    logic rdAny;
  } rtcStrobes_t;
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SEC_OFS    = 8'h08,
  parameter int SHADOW_OFS = 8'h0C,
  parameter int MS_OFS     = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output rtcStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] SecAddr    = ADDR_W'(SEC_OFS);
  localparam logic [ADDR_W-1:0] ShadowAddr = ADDR_W'(SHADOW_OFS);
  localparam logic [ADDR_W-1:0] MsAddr     = ADDR_W'(MS_OFS);

  logic hitSec, hitShadow, hitMs;

  always_comb begin
    hitSec    = (addr == SecAddr);
    hitShadow = (addr == ShadowAddr);
    hitMs     = (addr == MsAddr);
    strobes.loadSec   = wrEn & hitSec;
    strobes.capShadow = rdEn & hitMs;
    strobes.rdSec     = rdEn & hitSec;
    strobes.rdShadow  = rdEn & hitShadow;
    strobes.rdMs      = rdEn & hitMs;
    strobes.rdAny     = rdEn;
  end

  AST_RD_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdSec, strobes.rdShadow, strobes.rdMs})) else $error("rd select"); // R9
  AST_NO_RD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> !(strobes.capShadow || strobes.rdAny)) else $error("stray read"); // R10
  AST_WR_ONLY_SEC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSec |-> (wrEn && addr == SecAddr)) else $error("stray write"); // R8
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wrData,
  input  rtcStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData
);
  localparam int MS_W = $clog2(MS_PER_SEC);
  localparam logic [MS_W-1:0] MsTop = MS_W'(MS_PER_SEC - 1);

  logic [DATA_W-1:0] secCount;
  logic [DATA_W-1:0] shadowSec;
  logic [MS_W-1:0]   msCount;
  logic              msAtTop;
  logic [DATA_W-1:0] rdMux;

  assign msAtTop = (msCount == MsTop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCount <= '0;
      msCount  <= '0;
    end else if (strobes.loadSec) begin
      secCount <= wrData;
      msCount  <= '0;
    end else if (tickEn) begin
      if (msAtTop) begin
        msCount  <= '0;
        secCount <= secCount + 1'b1;
      end else begin
        msCount <= msCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowSec <= '0;
    else if (strobes.capShadow) shadowSec <= secCount;
  end

  always_comb begin
    rdMux = '0;
    if (strobes.rdSec)    rdMux = secCount;
    if (strobes.rdShadow) rdMux = shadowSec;
    if (strobes.rdMs)     rdMux = {{(DATA_W-MS_W){1'b0}}, msCount};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdAny) rdData <= rdMux;
  end

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    msCount <= MsTop) else $error("ms range"); // R3
  AST_MS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && msAtTop && !strobes.loadSec) |=>
      (msCount == '0 && secCount == $past(secCount) + 1'b1)) else $error("wrap"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobes.loadSec) |=> ($stable(msCount) && $stable(secCount))) else $error("idle"); // R2
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capShadow |=> shadowSec == $past(secCount)) else $error("capture"); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capShadow |=> $stable(shadowSec)) else $error("shadow hold"); // R6
  AST_LOAD_SEC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSec |=> (secCount == $past(wrData) && msCount == '0)) else $error("load"); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdAny |=> $stable(rdData)) else $error("rd hold"); // R9
endmodule

// File: rtl/rtcShadowTimer.sv
module rtcShadowTimer
  import rtcPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_OFS    = 8'h08,
  parameter int SHADOW_OFS = 8'h0C,
  parameter int MS_OFS     = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  rtcStrobes_t strobes;

  rtcCtrl #(
    .ADDR_W(ADDR_W), .SEC_OFS(SEC_OFS), .SHADOW_OFS(SHADOW_OFS), .MS_OFS(MS_OFS)
  ) i_rtcCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobes(strobes)
  );

  rtcDatapath #(
    .DATA_W(DATA_W), .MS_PER_SEC(MS_PER_SEC)
  ) i_rtcDatapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrData(wrData),
    .strobes(strobes), .rdData(rdData)
  );
endmodule

// File: tb/test_rtcShadowTimer.sv
module test_rtcShadowTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int unsigned nChecks = 0;
  int unsigned nFails = 0;
  logic [31:0] mSec = '0, mShadow = '0, mRd = '0;
  int          mMs = 0;
  logic [31:0] seed;

  always #4 clk = ~clk;

  rtcShadowTimer i_rtcShadowTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: rdData actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readModel(input logic [7:0] a);
    case (a)
      8'h08:   return mSec;
      8'h0C:   return mShadow;
      8'h10:   return 32'(mMs);
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle; model updates after the edge, result checked 1 ns later
  task automatic step(input logic tk, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    tickEn = tk; wrEn = wr; rdEn = rd; addr = a; wrData = d;
    @(posedge clk);
    #1;
    if (rd) begin
      mRd = readModel(a);
      if (a == 8'h10) mShadow = mSec;
    end
    if (wr && a == 8'h08) begin
      mSec = d; mMs = 0;
    end else if (tk) begin
      if (mMs == 999) begin mMs = 0; mSec = mSec + 1; end
      else mMs++;
    end
    check(tag, rdData, mRd);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b0, 1'b1, a, 32'h0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h08:   return "R2";
      8'h0C:   return "R6";
      8'h10:   return "R5";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", rdData, 32'h0);
    @(negedge clk) rstN = 1'b1;
    rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1");
    // R2 counting and idle hold
    ticks(5, "R2"); rd(8'h10, "R2");
    step(1'b0, 1'b0, 1'b0, 8'h10, 32'h0, "R9"); // no read: rdData holds
    rd(8'h10, "R2");
    // R7 write wins over tick in same cycle
    step(1'b1, 1'b1, 1'b0, 8'h08, 32'h12345678, "R7");
    rd(8'h08, "R7"); rd(8'h10, "R7");
    // R3 millisecond rollover
    ticks(999, "R3"); rd(8'h10, "R3"); rd(8'h08, "R3");
    ticks(1, "R3"); rd(8'h10, "R3"); rd(8'h08, "R3");
    // R5/R6/R10 capture and hold
    ticks(17, "R5"); rd(8'h10, "R5"); rd(8'h0C, "R5");
    step(1'b0, 1'b1, 1'b0, 8'h08, 32'd77, "R6");
    ticks(1000, "R6"); rd(8'h0C, "R6");
    rd(8'h08, "R10"); rd(8'h04, "R10"); rd(8'h0C, "R10");
    // R8 ignored writes
    step(1'b0, 1'b1, 1'b0, 8'h0C, 32'hDEADBEEF, "R8");
    step(1'b0, 1'b1, 1'b0, 8'h10, 32'h000001F0, "R8");
    step(1'b0, 1'b1, 1'b0, 8'h20, 32'hA5A5A5A5, "R8");
    rd(8'h0C, "R8"); rd(8'h10, "R8"); rd(8'h08, "R8");
    // R4 seconds wrap
    step(1'b0, 1'b1, 1'b0, 8'h08, 32'hFFFFFFFF, "R4");
    ticks(1000, "R4"); rd(8'h08, "R4"); rd(8'h10, "R4");
    // R9 unmapped reads
    rd(8'h00, "R9"); rd(8'h04, "R9"); rd(8'h14, "R9"); rd(8'hFC, "R9");
    // seeded random mix
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 6000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int          sel;
      sel = $urandom_range(0, 7);
      a = (sel < 2) ? 8'h10 : (sel < 4) ? 8'h0C : (sel < 6) ? 8'h08 : 8'($urandom);
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF - 32'($urandom_range(0, 2)) : $urandom;
      step($urandom_range(0, 9) < 8, $urandom_range(0, 15) == 0,
           $urandom_range(0, 2) == 0, a, d, tagFor(a));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule